// File: doc/BRIEF.md
# Shared Bus Transaction Controller

This controller ties several requesting masters to several memory-mapped slaves over one shared word-wide bus. A master raises a one-cycle request carrying direction, start address, word count and a lock flag. The controller holds it as outstanding and reports its progress on a per-master two-bit status. Masters act on the rising clock edge. The controller does all of its own work on the falling edge: absorbing new requests, choosing a winner, decoding the target slave, sampling the slave response and posting results. A value the bus changes is therefore never seen by a master in the same rising-edge phase in which it was made.

The arbitration policy lives outside the block. The controller shows the set of requests that may compete on `arb_req`, and an external arbiter answers with `arb_gnt` in the same cycle. Each slave owns an inclusive address window set by parameters. A slave answers every word transfer with WAIT, OK or ERROR. On WAIT the controller repeats the identical transfer until the slave finishes. A burst moves one word per OK answer. Each completed word is marked by a pulse on that master's `m_beat` bit, with read data on `m_rdata`.

Top module: `sbus_ctrl`

## Requirements
- R1: A synchronous active-high reset, sampled on both clock edges, empties the outstanding set. It sets every master status to OK and clears `m_beat`, `m_proto_err`, `arb_req` and `s_sel`.
- R2: Status codes are REQUEST=0, WAIT=1, OK=2 and ERROR=3. A request captured on a rising edge is absorbed at the following falling edge and shows REQUEST. It is first served at the falling edge after that. A finished status (OK or ERROR) can never step directly to WAIT.
- R3: `arb_req` shows every outstanding master, or nothing while the bus is held for one master. The master served is the lowest-index bit of `arb_gnt` AND outstanding. Losers keep REQUEST and compete again in later cycles.
- R4: The target slave j is the lowest-index slave whose window satisfies lo_j <= address <= hi_j, both ends inclusive. `s_sel` is one-hot or zero.
- R5: An address that hits no window completes at once with ERROR. No slave is selected, no beat is produced, and the rest of the burst is dropped.
- R6: When the slave answers WAIT (1), the master shows WAIT. The same slave, address and direction are presented again at the next falling edge. No other master is served until the slave answers OK or ERROR.
- R7: A slave answer of ERROR (3) sets the master to ERROR with no beat and drops the rest of the burst.
- R8: A burst of count n (n=0 treated as 1) yields n `m_beat` pulses, one per OK answer, at addresses start, start+1, and so on. Read data is on `m_rdata` in the cycle of the pulse. The final beat sets OK and the earlier beats leave WAIT. An unlocked burst re-competes between beats.
- R9: A locked request keeps the bus across all of its beats and reserves the following bus cycle for the same master's next request. The reservation is released if that master does not issue again.
- R10: A request raised while the master's status is REQUEST or WAIT is dropped. `m_proto_err` pulses for one cycle after that rising edge.
- R11: During a write transfer `s_write` is high and `s_wdata` carries the served master's `m_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; masters on rising edge, bus on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | NM | One-cycle request strobe per master |
| m_write | input | NM | Request direction, 1 = write |
| m_lock | input | NM | Request keeps the bus and reserves the next cycle |
| m_addr | input | NM*AW | Start word address per master |
| m_len | input | NM*LW | Word count per master (0 means one) |
| m_wdata | input | NM*DW | Write word per master, read when its beat is transferred |
| m_status | output | NM*2 | Per-master status code |
| m_proto_err | output | NM | Pulse: request dropped because one was pending |
| m_beat | output | NM | Pulse: one word of that master completed |
| m_rdata | output | DW | Read word of the completed beat |
| arb_req | output | NM | Masters allowed to compete this cycle |
| arb_gnt | input | NM | Arbiter choice |
| s_sel | output | NS | One-hot slave select |
| s_write | output | 1 | Transfer direction |
| s_addr | output | AW | Transfer word address |
| s_wdata | output | DW | Transfer write word |
| s_rdata | input | NS*DW | Read word from each slave |
| s_resp | input | NS*2 | Answer from each slave: 1 WAIT, 2 OK, 3 ERROR |

## Verification
The bench builds the block with three masters, two slaves, 8-bit addresses, 16-bit words and 4-bit counts. Slave 0 covers 0x00–0x1F and answers at once. Slave 1 covers 0x40–0x7F with two wait states and fails on 0x7E. The gap at 0x20–0x3F lets a burst run off the end of slave 0 into unmapped space. Slave 1 exercises the retry path, and three masters under a lowest-index arbiter make contention, locked and unlocked burst interleaving, and dropped second requests all reachable.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [1:0] {
    ST_REQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_OK   = 2'd2,
    ST_ERR  = 2'd3
  } bus_st_e;

  // A finished status (OK or ERROR) has the upper bit set.
  function automatic logic st_done(input logic [1:0] s);
    return s[1];
  endfunction

endpackage

// File: rtl/sbus_req_stage.sv
// Rising-edge capture of one master's request; drops it when one is pending.
module sbus_req_stage #(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          write,
  input  logic          lock,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  input  logic [1:0]    status,
  output logic          stg_v,
  output logic          stg_write,
  output logic          stg_lock,
  output logic [AW-1:0] stg_addr,
  output logic [LW-1:0] stg_cnt,
  output logic          proto_err
);
  import sbus_pkg::*;

  function automatic logic [LW-1:0] beats_of(input logic [LW-1:0] n);
    return (n == '0) ? LW'(1) : n;
  endfunction

  logic busy;
  assign busy = !st_done(status);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v     <= 1'b0;
      proto_err <= 1'b0;
      stg_write <= 1'b0;
      stg_lock  <= 1'b0;
      stg_addr  <= '0;
      stg_cnt   <= '0;
    end else begin
      stg_v     <= req && !busy;
      proto_err <= req && busy;
      stg_write <= write;
      stg_lock  <= lock;
      stg_addr  <= addr;
      stg_cnt   <= beats_of(len);
    end
  end

  // R10: a request against a pending one is flagged and not staged
  a_r10_drop_pending: assert property (@(posedge clk) disable iff (rst)
    (req && busy) |=> (proto_err && !stg_v))
    else $error("a_r10_drop_pending");

endmodule

// File: rtl/sbus_addr_decode.sv
// Inclusive window decode; lowest-index matching slave wins.
module sbus_addr_decode #(
  parameter int NS = 2,
  parameter int AW = 8,
  parameter logic [NS*AW-1:0] S_LO = '0,
  parameter logic [NS*AW-1:0] S_HI = '1
) (
  input  logic [AW-1:0] addr,
  output logic [NS-1:0] sel,
  output logic          hit
);
  // Offset form avoids comparing against a constant zero bound.
  function automatic logic in_win(input logic [AW-1:0] a,
                                  input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi);
    return (AW'(a - lo)) <= (AW'(hi - lo));
  endfunction

  logic [NS-1:0] raw;

  for (genvar g = 0; g < NS; g++) begin : g_win
    assign raw[g] = in_win(addr, S_LO[g*AW +: AW], S_HI[g*AW +: AW]);
  end

  assign sel = raw & (~raw + NS'(1));
  assign hit = |raw;

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl #(
  parameter int NM = 3,
  parameter int NS = 2,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 4,
  parameter logic [NS*AW-1:0] S_LO = 16'h4000,
  parameter logic [NS*AW-1:0] S_HI = 16'h7F1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NM-1:0]    m_req,
  input  logic [NM-1:0]    m_write,
  input  logic [NM-1:0]    m_lock,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*LW-1:0] m_len,
  input  logic [NM*DW-1:0] m_wdata,
  output logic [NM*2-1:0]  m_status,
  output logic [NM-1:0]    m_proto_err,
  output logic [NM-1:0]    m_beat,
  output logic [DW-1:0]    m_rdata,
  output logic [NM-1:0]    arb_req,
  input  logic [NM-1:0]    arb_gnt,
  output logic [NS-1:0]    s_sel,
  output logic             s_write,
  output logic [AW-1:0]    s_addr,
  output logic [DW-1:0]    s_wdata,
  input  logic [NS*DW-1:0] s_rdata,
  input  logic [NS*2-1:0]  s_resp
);
  import sbus_pkg::*;

  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  function automatic logic [NM-1:0] lowest(input logic [NM-1:0] v);
    return v & (~v + NM'(1));
  endfunction

  function automatic logic [IW-1:0] index_of(input logic [NM-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NM; i++) if (oh[i]) r = r | IW'(i);
    return r;
  endfunction

  // ---------------- rising-edge request stages ----------------
  logic [NM-1:0] stg_v, stg_write, stg_lock;
  logic [AW-1:0] stg_addr [NM];
  logic [LW-1:0] stg_cnt  [NM];
  bus_st_e       st       [NM];

  for (genvar gm = 0; gm < NM; gm++) begin : g_stage
    sbus_req_stage #(.AW(AW), .LW(LW)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .req       (m_req[gm]),
      .write     (m_write[gm]),
      .lock      (m_lock[gm]),
      .addr      (m_addr[gm*AW +: AW]),
      .len       (m_len[gm*LW +: LW]),
      .status    (st[gm]),
      .stg_v     (stg_v[gm]),
      .stg_write (stg_write[gm]),
      .stg_lock  (stg_lock[gm]),
      .stg_addr  (stg_addr[gm]),
      .stg_cnt   (stg_cnt[gm]),
      .proto_err (m_proto_err[gm])
    );
    assign m_status[gm*2 +: 2] = st[gm];
  end

  // ---------------- outstanding set (falling-edge state) ----------------
  logic [NM-1:0] pend, p_wr, p_lock;
  logic [AW-1:0] p_addr [NM];
  logic [LW-1:0] p_rem  [NM];
  logic          own_v;
  logic [IW-1:0] own_idx;

  // ---------------- selection ----------------
  logic [NM-1:0] cand, srv_vec;
  logic          srv_v;
  logic [IW-1:0] srv_idx;

  assign arb_req = own_v ? '0 : pend;

  always_comb begin
    cand = '0;
    if (own_v) cand[own_idx] = pend[own_idx];
    else       cand = arb_gnt & pend;
  end

  assign srv_vec = lowest(cand);
  assign srv_v   = |srv_vec;
  assign srv_idx = index_of(srv_vec);

  // ---------------- decode and slave drive ----------------
  logic [NS-1:0] dec_sel;
  logic          dec_hit;

  sbus_addr_decode #(.NS(NS), .AW(AW), .S_LO(S_LO), .S_HI(S_HI)) u_dec (
    .addr (p_addr[srv_idx]),
    .sel  (dec_sel),
    .hit  (dec_hit)
  );

  assign s_sel   = srv_v ? dec_sel : '0;
  assign s_addr  = p_addr[srv_idx];
  assign s_write = srv_v && p_wr[srv_idx];
  assign s_wdata = m_wdata[srv_idx*DW +: DW];

  logic [1:0]    sel_resp;
  logic [DW-1:0] sel_rdata;

  always_comb begin
    sel_resp  = '0;
    sel_rdata = '0;
    for (int j = 0; j < NS; j++) begin
      if (dec_sel[j]) begin
        sel_resp  = sel_resp  | s_resp[j*2 +: 2];
        sel_rdata = sel_rdata | s_rdata[j*DW +: DW];
      end
    end
  end

  // ---------------- named transfer events ----------------
  logic miss_ev, wait_ev, fail_ev, ok_ev, last_beat;
  assign miss_ev   = srv_v && !dec_hit;
  assign wait_ev   = srv_v && dec_hit && (sel_resp == ST_WAIT);
  assign fail_ev   = srv_v && dec_hit && !sel_resp[1];
  assign ok_ev     = srv_v && dec_hit && (sel_resp == ST_OK);
  assign last_beat = (p_rem[srv_idx] == LW'(1));

  logic err_any;
  assign err_any = miss_ev || (srv_v && dec_hit && (sel_resp == ST_ERR))
                 || (fail_ev && !wait_ev);

  // ---------------- falling-edge engine ----------------
  always_ff @(negedge clk) begin
    if (rst) begin
      pend    <= '0;
      p_wr    <= '0;
      p_lock  <= '0;
      own_v   <= 1'b0;
      own_idx <= '0;
      m_beat  <= '0;
      m_rdata <= '0;
      for (int i = 0; i < NM; i++) begin
        st[i]     <= ST_OK;
        p_addr[i] <= '0;
        p_rem[i]  <= '0;
      end
    end else begin
      m_beat <= '0;
      // absorb freshly staged requests
      for (int i = 0; i < NM; i++) begin
        if (stg_v[i]) begin
          pend[i]   <= 1'b1;
          p_wr[i]   <= stg_write[i];
          p_lock[i] <= stg_lock[i];
          p_addr[i] <= stg_addr[i];
          p_rem[i]  <= stg_cnt[i];
          st[i]     <= ST_REQ;
        end
      end
      // serve one transfer
      if (srv_v) begin
        if (err_any) begin
          pend[srv_idx] <= 1'b0;
          st[srv_idx]   <= ST_ERR;
          own_v         <= 1'b0;
        end else if (wait_ev) begin
          st[srv_idx] <= ST_WAIT;
          own_v       <= 1'b1;
          own_idx     <= srv_idx;
        end else if (ok_ev) begin
          m_beat[srv_idx] <= 1'b1;
          m_rdata         <= sel_rdata;
          own_v           <= p_lock[srv_idx];
          own_idx         <= srv_idx;
          if (last_beat) begin
            pend[srv_idx] <= 1'b0;
            st[srv_idx]   <= ST_OK;
          end else begin
            p_rem[srv_idx]  <= p_rem[srv_idx] - LW'(1);
            p_addr[srv_idx] <= p_addr[srv_idx] + AW'(1);
            st[srv_idx]     <= ST_WAIT;
          end
        end
      end else if (own_v && !stg_v[own_idx]) begin
        own_v <= 1'b0;   // reservation unused: release the bus
      end
    end
  end

  // ---------------- assertions ----------------
  // R4: at most one slave is driven
  a_r4_sel_onehot: assert property (@(negedge clk) disable iff (rst)
    $onehot0(s_sel))
    else $error("a_r4_sel_onehot");

  // R8: at most one word completes per bus cycle
  a_r8_beat_onehot: assert property (@(negedge clk) disable iff (rst)
    $onehot0(m_beat))
    else $error("a_r8_beat_onehot");

  // R6: a wait state repeats the identical transfer
  a_r6_retry_same: assert property (@(negedge clk) disable iff (rst)
    wait_ev |=> (s_addr == $past(s_addr) && s_sel == $past(s_sel)
                 && s_write == $past(s_write)))
    else $error("a_r6_retry_same");

  for (genvar gc = 0; gc < NM; gc++) begin : g_chk
    // R2: a finished master passes through REQUEST before WAIT
    a_r2_request_first: assert property (@(negedge clk) disable iff (rst)
      st_done(st[gc]) |=> (st[gc] != ST_WAIT))
      else $error("a_r2_request_first");

    // R5: an unmapped address ends the request with ERROR and no beat
    a_r5_miss_error: assert property (@(negedge clk) disable iff (rst)
      (miss_ev && srv_vec[gc]) |=> (st[gc] == ST_ERR && !m_beat[gc]))
      else $error("a_r5_miss_error");
  end

endmodule

// File: tb/sbus_ctrl_bench.sv
module sbus_ctrl_bench;
  localparam int NM = 3, NS = 2, AW = 8, DW = 16, LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [NM-1:0]    m_req = '0, m_write = '0, m_lock = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*LW-1:0] m_len = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic [NM*2-1:0]  m_status;
  logic [NM-1:0]    m_proto_err, m_beat, arb_req, arb_gnt;
  logic [DW-1:0]    m_rdata, s_wdata;
  logic [NS-1:0]    s_sel;
  logic             s_write;
  logic [AW-1:0]    s_addr;
  logic [NS*DW-1:0] s_rdata;
  logic [NS*2-1:0]  s_resp;

  sbus_ctrl u_sbus_ctrl (
    .clk(clk), .rst(rst), .m_req(m_req), .m_write(m_write), .m_lock(m_lock),
    .m_addr(m_addr), .m_len(m_len), .m_wdata(m_wdata), .m_status(m_status),
    .m_proto_err(m_proto_err), .m_beat(m_beat), .m_rdata(m_rdata),
    .arb_req(arb_req), .arb_gnt(arb_gnt), .s_sel(s_sel), .s_write(s_write),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_resp(s_resp)
  );

  // lowest-index arbiter
  assign arb_gnt = arb_req & (~arb_req + 3'd1);

  // slave models: 0 = fast 0x00-0x1F, 1 = two wait states 0x40-0x7F, error at 0x7E
  function automatic logic [15:0] seed0(input int a); return 16'h1000 + 16'(a * 3); endfunction
  function automatic logic [15:0] seed1(input int a); return 16'h2000 + 16'(a * 5); endfunction

  logic [15:0] mem0 [32];
  logic [15:0] mem1 [64];
  logic [1:0]  wcnt;

  always_comb begin
    s_resp[1:0]   = 2'd2;
    s_rdata[15:0] = mem0[s_addr[4:0]];
    s_resp[3:2]   = (wcnt < 2'd2) ? 2'd1 : ((s_addr == 8'h7E) ? 2'd3 : 2'd2);
    s_rdata[31:16] = mem1[s_addr[5:0]];
  end

  always @(negedge clk) begin
    if (rst) begin
      wcnt <= '0;
      for (int a = 0; a < 32; a++) mem0[a] <= seed0(a);
      for (int a = 0; a < 64; a++) mem1[a] <= seed1(a);
    end else begin
      if (s_sel[0] && s_write) mem0[s_addr[4:0]] <= s_wdata;
      if (s_sel[1]) begin
        if (wcnt < 2'd2) wcnt <= wcnt + 2'd1;
        else begin
          wcnt <= '0;
          if (s_write && s_addr != 8'h7E) mem1[s_addr[5:0]] <= s_wdata;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { int m; logic [15:0] d; bit chk; } exp_t;
  exp_t sbq [$];
  int vecs = 0, bad = 0;
  bit fin = 1'b0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic expect_beat(input int m, input logic [15:0] d, input bit chk);
    exp_t e;
    e.m = m; e.d = d; e.chk = chk;
    sbq.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      for (int i = 0; i < NM; i++) begin
        if (m_beat[i]) begin
          if (sbq.size() == 0) check(1'b0, "R8 unexpected beat", i, 99);
          else begin
            exp_t e;
            e = sbq.pop_front();
            check(e.m == i, "R3 beat order master", i, e.m);
            if (e.chk) check(m_rdata == e.d, "R8 read data", m_rdata, e.d);
          end
        end
      end
    end
  end

  // ---------------- driver helpers ----------------
  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic set_req(input int m, input bit wr, input bit lk, input logic [7:0] a,
                         input logic [3:0] n, input logic [15:0] wd);
    m_req[m] = 1'b1; m_write[m] = wr; m_lock[m] = lk;
    m_addr[m*AW +: AW] = a; m_len[m*LW +: LW] = n; m_wdata[m*DW +: DW] = wd;
  endtask

  task automatic clr();
    m_req = '0;
  endtask

  function automatic logic [1:0] stat(input int m);
    return m_status[m*2 +: 2];
  endfunction

  task automatic wait_done(input int m);
    int k = 0;
    while (!stat(m)[1] && k < 100) begin step(); k++; end
    if (k >= 100) check(1'b0, "R2 completion timeout", stat(m), 2);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      vecs++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    #2 rst = 1'b0;
    step();
    // R1 reset state
    for (int i = 0; i < NM; i++) check(stat(i) == 2'd2, "R1 status OK after reset", stat(i), 2);
    check(m_beat == '0 && arb_req == '0, "R1 no beat, no pending", {m_beat, arb_req}, 0);
    check(s_sel == '0, "R1 no slave selected", s_sel, 0);

    // R2/R4 single read from fast slave
    expect_beat(0, seed0(5), 1'b1);
    set_req(0, 1'b0, 1'b0, 8'h05, 4'd1, 16'h0); step(); clr();
    check(stat(0) == 2'd0, "R2 REQUEST after absorb", stat(0), 0);
    check(s_sel == 2'b01, "R4 decode to slave 0", s_sel, 1);
    step();
    check(stat(0) == 2'd2, "R2 OK after fast transfer", stat(0), 2);

    // R6 wait states on slow slave
    expect_beat(1, seed1(5), 1'b1);
    set_req(1, 1'b0, 1'b0, 8'h45, 4'd1, 16'h0); step(); clr();
    step();
    check(stat(1) == 2'd1, "R6 WAIT during wait state", stat(1), 1);
    check(s_sel == 2'b10 && s_addr == 8'h45, "R6 transfer reissued", {s_sel, s_addr}, 12'h245);
    wait_done(1);
    check(stat(1) == 2'd2, "R6 OK after waits", stat(1), 2);

    // R5 unmapped address
    set_req(2, 1'b0, 1'b0, 8'h30, 4'd1, 16'h0); step(); clr();
    check(s_sel == '0, "R5 no slave for gap", s_sel, 0);
    wait_done(2);
    check(stat(2) == 2'd3, "R5 ERROR for gap", stat(2), 3);

    // R5 burst runs off slave 0 into the gap: one beat, then ERROR
    expect_beat(2, seed0(31), 1'b1);
    set_req(2, 1'b0, 1'b0, 8'h1F, 4'd3, 16'h0); step(); clr();
    wait_done(2);
    check(stat(2) == 2'd3, "R5 burst abandoned with ERROR", stat(2), 3);

    // R8 burst of four
    for (int a = 2; a < 6; a++) expect_beat(0, seed0(a), 1'b1);
    set_req(0, 1'b0, 1'b0, 8'h02, 4'd4, 16'h0); step(); clr();
    wait_done(0);
    check(stat(0) == 2'd2, "R8 burst OK", stat(0), 2);

    // R3 contention: lower index first, loser stays REQUEST
    expect_beat(0, seed0(3), 1'b1);
    expect_beat(2, seed0(4), 1'b1);
    set_req(0, 1'b0, 1'b0, 8'h03, 4'd1, 16'h0);
    set_req(2, 1'b0, 1'b0, 8'h04, 4'd1, 16'h0);
    step(); clr();
    check(arb_req == 3'b101, "R3 outstanding set shown", arb_req, 5);
    step();
    check(stat(2) == 2'd0, "R3 loser keeps REQUEST", stat(2), 0);
    wait_done(2);

    // R8 unlocked burst is re-arbitrated between beats
    expect_beat(1, seed0(8), 1'b1);
    expect_beat(0, seed0(0), 1'b1);
    expect_beat(1, seed0(9), 1'b1);
    expect_beat(1, seed0(10), 1'b1);
    set_req(1, 1'b0, 1'b0, 8'h08, 4'd3, 16'h0); step(); clr();
    set_req(0, 1'b0, 1'b0, 8'h00, 4'd1, 16'h0); step(); clr();
    wait_done(1); wait_done(0);

    // R9 locked burst keeps the bus
    expect_beat(1, seed0(8), 1'b1);
    expect_beat(1, seed0(9), 1'b1);
    expect_beat(1, seed0(10), 1'b1);
    expect_beat(0, seed0(0), 1'b1);
    set_req(1, 1'b0, 1'b1, 8'h08, 4'd3, 16'h0); step(); clr();
    set_req(0, 1'b0, 1'b0, 8'h00, 4'd1, 16'h0); step(); clr();
    wait_done(1); wait_done(0);
    check(stat(0) == 2'd2, "R9 waiting master served after release", stat(0), 2);

    // R7 slave error after waits
    set_req(2, 1'b0, 1'b0, 8'h7E, 4'd1, 16'h0); step(); clr();
    wait_done(2);
    check(stat(2) == 2'd3, "R7 slave ERROR reported", stat(2), 3);

    // R10 second request while pending is dropped
    expect_beat(1, seed1(5), 1'b1);
    set_req(1, 1'b0, 1'b0, 8'h45, 4'd1, 16'h0); step();
    set_req(1, 1'b0, 1'b0, 8'h46, 4'd1, 16'h0); step(); clr();
    check(m_proto_err[1] == 1'b1, "R10 protocol error flagged", m_proto_err[1], 1);
    wait_done(1);
    check(stat(1) == 2'd2, "R10 first request completes", stat(1), 2);

    // R11 writes: fast single, slow burst, then read back
    expect_beat(0, 16'h0, 1'b0);
    set_req(0, 1'b1, 1'b0, 8'h10, 4'd1, 16'hBEEF); step(); clr();
    wait_done(0);
    expect_beat(0, 16'hBEEF, 1'b1);
    set_req(0, 1'b0, 1'b0, 8'h10, 4'd1, 16'h0); step(); clr();
    wait_done(0);

    expect_beat(2, 16'h0, 1'b0);
    expect_beat(2, 16'h0, 1'b0);
    set_req(2, 1'b1, 1'b0, 8'h50, 4'd2, 16'h1234); step(); clr();
    check(s_write && s_wdata == 16'h1234 && s_sel == 2'b10, "R11 write drive",
          {s_write, s_wdata}, 17'h11234);
    wait_done(2);
    expect_beat(2, 16'h1234, 1'b1);
    expect_beat(2, 16'h1234, 1'b1);
    set_req(2, 1'b0, 1'b0, 8'h50, 4'd2, 16'h0); step(); clr();
    wait_done(2);
    check(stat(2) == 2'd2, "R8 readback burst OK", stat(2), 2);

    repeat (4) step();
    check(sbq.size() == 0, "R8 all expected beats seen", sbq.size(), 0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule